// File: doc/BRIEF.md
# RTC Interrupt and Square-Wave Controller

This block holds the control byte and the status byte of a real-time clock and drives a single shared output pin. It runs on the 32.768 kHz oscillator clock. In wave mode the pin carries a square wave picked from four rates, made by a free-running divider. In interrupt mode the pin is an active-low alarm request, gated per alarm by an enable bit.

The surrounding clock logic supplies one-cycle match pulses for two alarms and a level that is high while the oscillator is stopped. Each alarm pulse sets a sticky flag. A rising edge of "oscillator stopped", which includes software turning the oscillator off, sets a sticky stop flag. Software reads and writes both bytes through a simple port. A write can clear a flag but can never set one.

Top module: `rtc_wave_irq`

## Requirements
- R1: After reset the control byte reads 0x00 and the status byte reads 0x80, with only the stop flag set. The pin then carries the slowest wave.
- R2: The control byte lives at address 0x0E and holds all eight written bits. Bit 7 turns the oscillator off when 1. Bits 4:3 select the rate. Bit 2 selects interrupt mode. Bit 1 enables alarm 2 and bit 0 enables alarm 1. Bits 6:5 have no function and read back as written.
- R3: In wave mode (bit 2 = 0) the pin follows a count of clock edges since reset release. Rate 00 gives count bit 14 (1 Hz), 01 gives bit 2 (4.096 kHz), 10 gives bit 1 (8.192 kHz), and 11 gives the clock itself (32.768 kHz).
- R4: In interrupt mode the pin is low exactly while (alarm-1 flag AND alarm-1 enable) OR (alarm-2 flag AND alarm-2 enable) holds, and high otherwise. The rate bits have no effect.
- R5: An alarm whose enable is 0 never pulls the pin low. In wave mode no flag affects the pin.
- R6: The status byte lives at address 0x0F. Bit 7 is the stop flag, bit 1 is the alarm-2 flag and bit 0 is the alarm-1 flag. Bits 6:2 always read 0.
- R7: An alarm match pulse sampled at a clock edge sets that alarm's flag at the same edge.
- R8: Writing 0 to a status flag bit clears it. Writing 1 leaves it unchanged. This applies to all three flags.
- R9: If a match pulse and a clearing write hit the same flag at the same edge, the flag ends up set.
- R10: The stop flag is set one edge after "oscillator stopped" (stop input OR control bit 7) rises. A stop level that stays high does not set the flag again after software clears it.
- R11: Reads of any address other than 0x0E and 0x0F return 0. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz oscillator clock |
| rstN | input | 1 | Active-low power-on reset |
| regAddr | input | 8 | Register address for reads and writes |
| regWrEn | input | 1 | Write strobe, sampled at the clock edge |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr, combinational |
| alarm1Match | input | 1 | Alarm 1 match pulse |
| alarm2Match | input | 1 | Alarm 2 match pulse |
| oscStop | input | 1 | High while the oscillator is stopped |
| sqwIntN | output | 1 | Shared square-wave / active-low interrupt pin |

## Verification
A write or a match pulse that is present at a rising edge shows up in the read data and on the pin right after that same edge, because both are combinational from the registers. The bench therefore drives at a falling edge and checks at the next falling edge. A stop caused by control bit 7 reaches the status byte one edge later than the write, since the edge detector sees the stored bit, and the bench waits that extra edge. Wave outputs are compared at falling edges with bits of the bench's own edge count since reset release. The clock-rate wave is also checked once in the clock's high phase.

// File: rtl/rtc_wave_pkg.sv
package rtc_wave_pkg;

  // control byte bit positions (the rate pair is decoded as one field)
  localparam int unsigned OSC_OFF_BIT = 7;
  localparam int unsigned RATE_HI_BIT = 4;
  localparam int unsigned RATE_LO_BIT = 3;
  localparam int unsigned IRQ_MODE_BIT = 2;
  localparam int unsigned ALARM_CNT = 2;

  // status flag order inside the strobe clear mask: {stop, alarm2, alarm1}
  localparam int unsigned FLAG_CNT = ALARM_CNT + 1;

  typedef enum logic [1:0] {
    RATE_SLOW = 2'b00,
    RATE_4K   = 2'b01,
    RATE_8K   = 2'b10,
    RATE_FULL = 2'b11
  } rate_e;

  typedef struct packed {
    logic                 ctrlWr;
    logic                 statWr;
    logic [7:0]           ctrlData;
    logic [FLAG_CNT-1:0]  statClr;
    logic [ALARM_CNT-1:0] alarmSet;
    logic                 oscSet;
  } strobe_t;

endpackage

// File: rtl/rtc_wave_ctrl.sv
module rtc_wave_ctrl
  import rtc_wave_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0E,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic              alarm1Match,
  input  logic              alarm2Match,
  input  logic              oscStop,
  input  logic              oscDisabled,
  output strobe_t           strb
);

  logic stopNow;
  logic stopPrev;
  logic hitCtrl;
  logic hitStat;

  assign stopNow = oscStop | oscDisabled;
  assign hitCtrl = (regAddr == CTRL_ADDR);
  assign hitStat = (regAddr == STAT_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopPrev <= 1'b0;
    end else begin
      stopPrev <= stopNow;
    end
  end

  always_comb begin
    strb          = '0;
    strb.ctrlWr   = regWrEn & hitCtrl;
    strb.statWr   = regWrEn & hitStat;
    strb.ctrlData = regWrData;
    // a zero written to a flag bit requests its clear
    strb.statClr  = {~regWrData[7], ~regWrData[1:0]};
    strb.alarmSet = {alarm2Match, alarm1Match};
    strb.oscSet   = stopNow & ~stopPrev;
  end

  // R10
  osc_level_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    oscStop |=> !strb.oscSet);

  // R11
  stray_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !hitCtrl && !hitStat) |-> !(strb.ctrlWr || strb.statWr));

endmodule

// File: rtl/rtc_wave_dp.sv
module rtc_wave_dp
  import rtc_wave_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0E,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0F,
  parameter int unsigned DIV_W = 15,
  parameter int unsigned TAP_4K = 2,
  parameter int unsigned TAP_8K = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regRdData,
  output logic              oscDisabled,
  output logic              sqwIntN
);

  localparam int unsigned TAP_SLOW = DIV_W - 1;

  logic [7:0]           ctrlReg;
  logic [DIV_W-1:0]     divCnt;
  logic [ALARM_CNT-1:0] alarmFlag;
  logic                 osfFlag;
  logic [ALARM_CNT-1:0] alarmEn;
  logic                 irqMode;
  rate_e                rateSel;
  logic                 waveOut;
  logic                 irqActive;
  logic [7:0]           statusByte;

  assign alarmEn     = ctrlReg[ALARM_CNT-1:0];
  assign irqMode     = ctrlReg[IRQ_MODE_BIT];
  assign rateSel     = rate_e'(ctrlReg[RATE_HI_BIT:RATE_LO_BIT]);
  assign oscDisabled = ctrlReg[OSC_OFF_BIT];

  // control byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= 8'h00;
    end else if (strb.ctrlWr) begin
      ctrlReg <= strb.ctrlData;
    end
  end

  // free-running divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // alarm flags: a match beats a clear in the same cycle
  for (genvar g = 0; g < ALARM_CNT; g++) begin : gAlarm
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        alarmFlag[g] <= 1'b0;
      end else if (strb.alarmSet[g]) begin
        alarmFlag[g] <= 1'b1;
      end else if (strb.statWr && strb.statClr[g]) begin
        alarmFlag[g] <= 1'b0;
      end
    end

    // R7 R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.alarmSet[g] |=> alarmFlag[g]);

    // R8
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.statWr && !strb.statClr[g] && alarmFlag[g]) |=> alarmFlag[g]);
  end

  // stop flag: set at power-up and on each stop edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      osfFlag <= 1'b1;
    end else if (strb.oscSet) begin
      osfFlag <= 1'b1;
    end else if (strb.statWr && strb.statClr[FLAG_CNT-1]) begin
      osfFlag <= 1'b0;
    end
  end

  // R10
  osf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.oscSet |=> osfFlag);

  // R8
  osf_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statWr && !strb.statClr[FLAG_CNT-1] && osfFlag) |=> osfFlag);

  // rate selection
  always_comb begin
    unique case (rateSel)
      RATE_SLOW: waveOut = divCnt[TAP_SLOW];
      RATE_4K:   waveOut = divCnt[TAP_4K];
      RATE_8K:   waveOut = divCnt[TAP_8K];
      default:   waveOut = clk;
    endcase
  end

  assign irqActive = |(alarmFlag & alarmEn);
  assign sqwIntN   = irqMode ? ~irqActive : waveOut;

  // R5
  no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqMode && alarmEn == '0) |-> sqwIntN);

  // R4
  irq_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqMode && alarmFlag[0] && alarmEn[0]) |-> !sqwIntN);

  // read path
  assign statusByte = {osfFlag, 5'b00000, alarmFlag};

  always_comb begin
    if (regAddr == CTRL_ADDR) begin
      regRdData = ctrlReg;
    end else if (regAddr == STAT_ADDR) begin
      regRdData = statusByte;
    end else begin
      regRdData = 8'h00;
    end
  end

  // R6
  stat_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == STAT_ADDR) |-> (regRdData[6:2] == 5'b00000));

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlWr |=> (ctrlReg == $past(strb.ctrlData)));

endmodule

// File: rtl/rtc_wave_irq.sv
module rtc_wave_irq
  import rtc_wave_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0E,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0F,
  parameter int unsigned DIV_W = 15,
  parameter int unsigned TAP_4K = 2,
  parameter int unsigned TAP_8K = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              alarm1Match,
  input  logic              alarm2Match,
  input  logic              oscStop,
  output logic              sqwIntN
);

  strobe_t strb;
  logic    oscDisabled;

  rtc_wave_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .alarm1Match(alarm1Match),
    .alarm2Match(alarm2Match), .oscStop(oscStop),
    .oscDisabled(oscDisabled), .strb(strb)
  );

  rtc_wave_dp #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR),
    .DIV_W(DIV_W), .TAP_4K(TAP_4K), .TAP_8K(TAP_8K)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regRdData(regRdData), .oscDisabled(oscDisabled), .sqwIntN(sqwIntN)
  );

endmodule

// File: tb/tb_rtc_wave_irq.sv
module tb_rtc_wave_irq;

  localparam logic [7:0] A_CTRL = 8'h0E;
  localparam logic [7:0] A_STAT = 8'h0F;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       alarm1Match = 1'b0;
  logic       alarm2Match = 1'b0;
  logic       oscStop = 1'b0;
  logic       sqwIntN;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // bench model
  logic [7:0]  mCtrl = 8'h00;
  logic [7:0]  mStat = 8'h80;
  logic        mPrev = 1'b0;
  logic [31:0] cyc = 0;

  rtc_wave_irq dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .alarm1Match(alarm1Match), .alarm2Match(alarm2Match),
    .oscStop(oscStop), .sqwIntN(sqwIntN)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      report();
    end
  end

  task automatic expect8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic expPin();
    if (mCtrl[2])
      return !((mStat[0] & mCtrl[0]) | (mStat[1] & mCtrl[1]));
    case (mCtrl[4:3])
      2'b00:   return cyc[14];
      2'b01:   return cyc[2];
      2'b10:   return cyc[1];
      default: return clk;
    endcase
  endfunction

  function automatic logic [7:0] nextStat(input logic [7:0] s, input logic a1, input logic a2,
                                          input logic ev, input logic wst, input logic [7:0] d);
    logic [7:0] n;
    n = s;
    if (a1) n[0] = 1'b1; else if (wst && !d[0]) n[0] = 1'b0;
    if (a2) n[1] = 1'b1; else if (wst && !d[1]) n[1] = 1'b0;
    if (ev) n[7] = 1'b1; else if (wst && !d[7]) n[7] = 1'b0;
    return n;
  endfunction

  // one clock edge: drive at falling edge, model at rising edge, return at falling edge
  task automatic tick(input logic a1, input logic a2, input logic wr,
                      input logic [7:0] addr, input logic [7:0] data);
    logic stopNow;
    logic ev;
    alarm1Match = a1; alarm2Match = a2;
    regWrEn = wr; regAddr = addr; regWrData = data;
    @(posedge clk);
    stopNow = oscStop | mCtrl[7];
    ev = stopNow & !mPrev;
    mPrev = stopNow;
    mStat = nextStat(mStat, a1, a2, ev, wr && addr == A_STAT, data);
    if (wr && addr == A_CTRL) mCtrl = data;
    @(negedge clk);
    alarm1Match = 1'b0; alarm2Match = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, regAddr, 8'h00);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] data);
    tick(1'b0, 1'b0, 1'b1, addr, data);
  endtask

  task automatic rd(input logic [7:0] addr, output logic [7:0] val);
    regAddr = addr;
    #1;
    val = regRdData;
  endtask

  task automatic checkRegs(input string req);
    logic [7:0] v;
    rd(A_CTRL, v);
    expect8({req, " ctrl"}, v, mCtrl);
    rd(A_STAT, v);
    expect8({req, " status"}, v, mStat);
  endtask

  task automatic checkPin(input string req);
    #1;
    expect8({req, " pin"}, {7'd0, sqwIntN}, {7'd0, expPin()});
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkRegs("R1");
    checkPin("R1");

    // R8 writing ones to status sets nothing, keeps stop flag
    wr(A_STAT, 8'hFF);
    checkRegs("R8 write-ones");
    checkRegs("R6 pad bits");

    // R3 rates
    wr(A_CTRL, 8'h08);
    for (int i = 0; i < 12; i++) begin idle(1); checkPin("R3 4k"); end
    wr(A_CTRL, 8'h10);
    for (int i = 0; i < 6; i++) begin idle(1); checkPin("R3 8k"); end
    wr(A_CTRL, 8'h18);
    for (int i = 0; i < 3; i++) begin
      idle(1); checkPin("R3 full low");
      @(posedge clk); #5;
      expect8("R3 full high pin", {7'd0, sqwIntN}, 8'h01);
      @(negedge clk);
    end
    wr(A_CTRL, 8'h00);
    for (int i = 0; i < 40; i++) begin idle(1000); checkPin("R3 1Hz"); end

    // R2 control byte layout and readback
    wr(A_CTRL, 8'h7F);
    checkRegs("R2");
    wr(A_CTRL, 8'h60);
    checkRegs("R2 spare bits");

    // R8 clear all flags
    wr(A_STAT, 8'h00);
    checkRegs("R8 clear");

    // R7 R5 R4 alarm flags and enables
    wr(A_CTRL, 8'h04);
    tick(1'b1, 1'b0, 1'b0, A_STAT, 8'h00);
    checkRegs("R7 alarm1");
    checkPin("R5 no enable");
    wr(A_CTRL, 8'h05);
    checkPin("R4 alarm1 enabled");
    wr(A_CTRL, 8'h1D);
    for (int i = 0; i < 5; i++) begin idle(1); checkPin("R4 rate ignored"); end
    wr(A_CTRL, 8'h06);
    checkPin("R5 alarm2 only enabled");
    tick(1'b0, 1'b1, 1'b0, A_STAT, 8'h00);
    checkRegs("R7 alarm2");
    checkPin("R4 alarm2");
    wr(A_CTRL, 8'h04);
    checkPin("R5 both disabled");
    wr(A_CTRL, 8'h13);
    for (int i = 0; i < 6; i++) begin idle(1); checkPin("R5 wave mode ignores flags"); end
    wr(A_CTRL, 8'h07);
    wr(A_STAT, 8'hFE);
    checkRegs("R8 clear alarm1 only");
    checkPin("R4 alarm2 remains");
    wr(A_STAT, 8'h00);
    checkPin("R4 released");

    // R9 set beats clear
    wr(A_CTRL, 8'h05);
    tick(1'b1, 1'b0, 1'b1, A_STAT, 8'h00);
    checkRegs("R9");
    checkPin("R9");
    tick(1'b0, 1'b1, 1'b1, A_STAT, 8'h00);
    checkRegs("R9 alarm2");
    wr(A_STAT, 8'h00);

    // R10 stop flag
    oscStop = 1'b1;
    idle(1);
    checkRegs("R10 stop edge");
    wr(A_STAT, 8'h00);
    checkRegs("R10 cleared");
    idle(3);
    checkRegs("R10 level no reset");
    oscStop = 1'b0;
    idle(1);
    oscStop = 1'b1;
    idle(1);
    checkRegs("R10 second edge");
    oscStop = 1'b0;
    wr(A_STAT, 8'h00);
    wr(A_CTRL, 8'h80);
    checkRegs("R10 off written");
    idle(1);
    checkRegs("R10 off sets flag");
    wr(A_CTRL, 8'h00);
    wr(A_STAT, 8'h00);
    checkRegs("R10 restored");

    // R11 stray addresses
    wr(A_CTRL, 8'h15);
    tick(1'b1, 1'b0, 1'b0, A_STAT, 8'h00);
    wr(8'h10, 8'h00);
    wr(8'h0D, 8'hFF);
    checkRegs("R11 unchanged");
    rd(8'h10, v);
    expect8("R11 read other", v, 8'h00);
    rd(8'h00, v);
    expect8("R11 read zero addr", v, 8'h00);

    // random interrupt-mode traffic (R4 R7 R8 R9)
    for (int i = 0; i < 300; i++) begin
      logic a1, a2, w;
      logic [7:0] addr, data;
      int sel;
      a1 = ($urandom % 4) == 0;
      a2 = ($urandom % 4) == 0;
      sel = $urandom % 8;
      w = sel < 3;
      if (sel == 0) begin
        addr = A_CTRL;
        data = {3'b000, 2'($urandom), 1'b1, 2'($urandom)};
      end else begin
        addr = A_STAT;
        data = 8'($urandom);
      end
      tick(a1, a2, w, addr, data);
      checkRegs("R8 random");
      checkPin("R4 random");
    end

    finished = 1'b1;
    report();
  end

endmodule